// File: doc/BRIEF.md
# Edge Period and Windowed Pulse Meter

This block watches one encoder phase input and reports either how long the signal takes from one rising edge to the next, or how many rising edges arrive inside a fixed time window. A single enable input starts and stops the measurement. A mode input selects one of the two measurements. The result appears on three byte-wide output registers. A sticky status flag signals that a fresh value is present.

In period mode, a prescaler divides the system clock into a tick, which is 200 ns at the default divide ratio with a 200 MHz clock. The block counts the ticks between consecutive rising edges and produces a 24-bit value. In window mode, the block counts ticks into milliseconds and milliseconds into a window whose length comes from an input. It counts the rising edges seen during the window, and the 16-bit total replaces the previous result at once when the window closes.

The outputs form a register image, not a stream. The outputs have no valid/ready pair and ignore back-pressure. A reader samples the bytes at any time, and every new result overwrites the previous one. The position counter and the host-side protocol belong to the surrounding logic.

Top module: `pfm_meter`

## Requirements
- R1: After reset, all three result bytes are zero and `res_ready` is low.
- R2: While `meas_en` is low, rising edges on `enc_a` have no effect. `res_ready` stays low and the result bytes keep their last value.
- R3: In period mode (`win_mode` = 0), the result equals floor(N / TICK_DIV), where N is the number of clock cycles between two consecutive rising edges of `enc_a`.
- R4: After enabling, or after a restart, the first rising edge only starts a period. It produces no result.
- R5: Period results are placed as follows: bits 7:0 on `data_b2`, bits 15:8 on `data_b3`, and bits 23:16 on `data_b4`.
- R6: If the tick count reaches PER_LIMIT before the next edge arrives, the block publishes PER_LIMIT. This happens TICK_DIV*PER_LIMIT cycles after the starting edge, and the default PER_LIMIT is all ones in 24 bits. The next edge then starts a fresh period and produces no result.
- R7: In window mode (`win_mode` = 1), the block counts the rising edges inside a window of TICK_DIV*TICKS_PER_MS*W cycles that starts at enable, where W is `win_len_ms` and a value of 0 counts as 1. At the window end, the count goes to bits 7:0 on `data_b3` and bits 15:8 on `data_b4`, and `data_b2` reads zero.
- R8: `res_ready` sets on the first result and stays set until `meas_en` is low at a clock edge. It then reads low from that edge on.
- R9: A change of `win_mode` while enabled restarts the measurement. `res_ready` clears at the next edge, and in period mode two edges are then needed for a new result.
- R10: Windows follow one another without a gap, and each window reports only its own edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | Measurement enable (control bit 1) |
| win_mode | input | 1 | 0: period timing, 1: windowed edge count |
| win_len_ms | input | 16 | Window length in milliseconds, 0 treated as 1 |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| data_b2 | output | 8 | Result byte 2 |
| data_b3 | output | 8 | Result byte 3 |
| data_b4 | output | 8 | Result byte 4 |
| res_ready | output | 1 | Sticky fresh-result flag (status bit 1) |

## Verification
An edge on `enc_a` takes effect at the third rising clock edge after the input rises, because of the two-flop synchronizer and the edge register. A period result is visible in the cycle that edge is taken. The bench therefore spaces its pulses by exact cycle counts and samples well after the third edge. A window result appears exactly TICK_DIV*TICKS_PER_MS*W cycles after the enabling edge, and a timeout appears TICK_DIV*PER_LIMIT cycles after the starting edge. The bench counts falling edges from the stimulus and checks the result both one cycle before the due cycle and in the due cycle. A drop of `res_ready` is checked at the falling edge right after the clock edge that samples the change on `meas_en` or `win_mode`.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int RES_W  = 24;
  localparam int WIN_W  = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;

  typedef enum logic {
    MODE_PERIOD = 1'b0,
    MODE_WINDOW = 1'b1
  } meas_mode_e;
endpackage

// File: rtl/pfm_tick_gen.sv
module pfm_tick_gen #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pre_q <= '0;
    else if (clr || tick) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  // R3: the prescaler never runs past its divide ratio
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
endmodule

// File: rtl/pfm_edge_det.sv
module pfm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1_q, s2_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign rise = s2_q & ~d_q;
endmodule

// File: rtl/pfm_period.sv
module pfm_period #(
  parameter int RES_W = 24,
  parameter int LIMIT = 16777215
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             rise,
  output logic             pub,
  output logic [RES_W-1:0] res
);
  localparam logic [RES_W-1:0] LIM = RES_W'(LIMIT);

  logic             armed_q;
  logic [RES_W-1:0] cnt_q;
  logic             timeout;

  assign timeout = armed_q && !rise && tick && (cnt_q == LIM - 1'b1);

  always_comb begin
    pub = 1'b0;
    res = cnt_q;
    if (!clr && armed_q && rise) begin
      pub = 1'b1;
      res = tick ? cnt_q + 1'b1 : cnt_q;
    end else if (!clr && timeout) begin
      pub = 1'b1;
      res = LIM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (rise) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (timeout) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R6: the running count stays below the saturation limit
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LIM);
endmodule

// File: rtl/pfm_window.sv
module pfm_window #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16,
  parameter int TPM   = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             rise,
  input  logic [LEN_W-1:0] win_len,
  output logic             pub,
  output logic [CNT_W-1:0] res
);
  localparam int MW = (TPM > 1) ? $clog2(TPM) : 1;
  localparam logic [MW-1:0] MS_LAST = MW'(TPM - 1);

  logic [MW-1:0]    mcnt_q;
  logic [LEN_W-1:0] wcnt_q, len_last;
  logic [CNT_W-1:0] ecnt_q;
  logic             ms_p, win_end, room;

  assign len_last = (win_len == '0) ? '0 : win_len - 1'b1;
  assign ms_p     = tick && (mcnt_q == MS_LAST);
  assign win_end  = ms_p && (wcnt_q >= len_last);
  assign room     = (ecnt_q != '1);
  assign pub      = win_end && !clr;
  assign res      = (rise && room) ? ecnt_q + 1'b1 : ecnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt_q <= '0;
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (clr) begin
      mcnt_q <= '0;
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      if (ms_p)      mcnt_q <= '0;
      else if (tick) mcnt_q <= mcnt_q + 1'b1;
      if (win_end)   wcnt_q <= '0;
      else if (ms_p) wcnt_q <= wcnt_q + 1'b1;
      if (win_end)           ecnt_q <= '0;
      else if (rise && room) ecnt_q <= ecnt_q + 1'b1;
    end
  end

  // R7: the millisecond divider stays inside its range
  p_ms_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt_q <= MS_LAST);
endmodule

// File: rtl/pfm_meter.sv
module pfm_meter
  import pfm_pkg::*;
#(
  parameter int TICK_DIV     = 40,
  parameter int TICKS_PER_MS = 5000,
  parameter int PER_LIMIT    = 16777215
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_en,
  input  logic              win_mode,
  input  logic [LEN_W-1:0]  win_len_ms,
  input  logic              enc_a,
  output logic [BYTE_W-1:0] data_b2,
  output logic [BYTE_W-1:0] data_b3,
  output logic [BYTE_W-1:0] data_b4,
  output logic              res_ready
);
  localparam int PAD_W = RES_W - WIN_W;

  meas_mode_e       mode_q;
  logic             clr, per_clr, win_clr, tick_clr;
  logic             rise, tick;
  logic             per_pub, win_pub;
  logic [RES_W-1:0] per_res, res_q;
  logic [WIN_W-1:0] win_res;
  logic             rdy_q;

  assign clr      = !meas_en || (meas_mode_e'(win_mode) != mode_q);
  assign per_clr  = clr || win_mode;
  assign win_clr  = clr || !win_mode;
  assign tick_clr = clr || (!win_mode && rise);

  pfm_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .din(enc_a), .rise(rise)
  );

  pfm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  pfm_period #(.RES_W(RES_W), .LIMIT(PER_LIMIT)) u_period (
    .clk(clk), .rst_n(rst_n), .clr(per_clr), .tick(tick), .rise(rise),
    .pub(per_pub), .res(per_res)
  );

  pfm_window #(.CNT_W(WIN_W), .LEN_W(LEN_W), .TPM(TICKS_PER_MS)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .tick(tick), .rise(rise),
    .win_len(win_len_ms), .pub(win_pub), .res(win_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PERIOD;
      res_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      mode_q <= meas_mode_e'(win_mode);
      if (per_pub)      res_q <= per_res;
      else if (win_pub) res_q <= {win_res, {PAD_W{1'b0}}};
      if (clr)                     rdy_q <= 1'b0;
      else if (per_pub || win_pub) rdy_q <= 1'b1;
    end
  end

  assign data_b2   = res_q[BYTE_W-1:0];
  assign data_b3   = res_q[2*BYTE_W-1:BYTE_W];
  assign data_b4   = res_q[3*BYTE_W-1:2*BYTE_W];
  assign res_ready = rdy_q;

  // R8: disabling drops the flag at the next edge
  p_rdy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> !res_ready);

  // R9: a mode change while enabled restarts and clears the flag
  p_mode_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && (meas_mode_e'(win_mode) != mode_q)) |=> !res_ready);

  // R7: a fresh window result never carries data in byte 2
  p_win_b2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready && mode_q == MODE_WINDOW) |-> (data_b2 == '0));
endmodule

// File: tb/pfm_meter_tb.sv
`timescale 1ns/1ps
module pfm_meter_tb;
  localparam int DIV = 4;
  localparam int TPM = 5;
  localparam int LIM = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_en = 1'b0;
  logic        win_mode = 1'b0;
  logic [15:0] win_len_ms = 16'd0;
  logic        enc_a = 1'b0;
  logic [7:0]  data_b2, data_b3, data_b4;
  logic        res_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfm_meter #(.TICK_DIV(DIV), .TICKS_PER_MS(TPM), .PER_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .win_mode(win_mode),
    .win_len_ms(win_len_ms), .enc_a(enc_a), .data_b2(data_b2),
    .data_b3(data_b3), .data_b4(data_b4), .res_ready(res_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] per_val();
    return {8'h0, data_b4, data_b3, data_b2};
  endfunction

  function automatic logic [31:0] win_val();
    return {16'h0, data_b4, data_b3};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one rising edge now, next one may follow gap cycles later
  task automatic pulse(input int gap);
    enc_a = 1'b1;
    wait_n(2);
    enc_a = 1'b0;
    wait_n(gap - 2);
  endtask

  task automatic t_reset();
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 bytes", per_val(), 32'h0);
    check("R1 ready", {31'b0, res_ready}, 32'h0);
  endtask

  task automatic t_period();
    win_mode = 1'b0;
    meas_en  = 1'b1;
    wait_n(3);
    pulse(40);
    check("R4 first edge arms only", {31'b0, res_ready}, 32'h0);
    pulse(29);
    check("R3 period 40 cycles", per_val(), 32'd10);
    check("R8 ready set", {31'b0, res_ready}, 32'h1);
    pulse(1100);
    check("R3 period 29 cycles", per_val(), 32'd7);
    pulse(20);
    check("R5 byte2", {24'h0, data_b2}, 32'h13);
    check("R5 byte3", {24'h0, data_b3}, 32'h01);
    check("R5 byte4", {24'h0, data_b4}, 32'h00);
  endtask

  task automatic t_disabled();
    meas_en = 1'b0;
    wait_n(1);
    check("R8 ready drops", {31'b0, res_ready}, 32'h0);
    pulse(10);
    pulse(10);
    pulse(10);
    check("R2 bytes held", per_val(), 32'd275);
    check("R2 ready low", {31'b0, res_ready}, 32'h0);
  endtask

  task automatic t_timeout();
    meas_en = 1'b1;
    wait_n(3);
    enc_a = 1'b1;
    for (int k = 1; k <= 3 + DIV * LIM; k++) begin
      @(negedge clk);
      if (k == 2) enc_a = 1'b0;
      if (k == 2 + DIV * LIM)
        check("R6 not before limit", {31'b0, res_ready}, 32'h0);
    end
    check("R6 timeout ready", {31'b0, res_ready}, 32'h1);
    check("R6 timeout value", per_val(), 32'd300);
    pulse(40);
    check("R6 next edge rearms", per_val(), 32'd300);
    pulse(20);
    check("R6 fresh period", per_val(), 32'd10);
  endtask

  task automatic t_mode_switch();
    win_mode = 1'b1;
    wait_n(1);
    check("R9 ready clears", {31'b0, res_ready}, 32'h0);
    wait_n(2);
    win_mode = 1'b0;
    wait_n(3);
    pulse(40);
    check("R9 first edge after restart", {31'b0, res_ready}, 32'h0);
    pulse(20);
    check("R9 period after restart", per_val(), 32'd10);
    check("R9 ready after restart", {31'b0, res_ready}, 32'h1);
  endtask

  task automatic t_window();
    meas_en    = 1'b0;
    win_mode   = 1'b1;
    win_len_ms = 16'd10;
    wait_n(2);
    meas_en = 1'b1;
    wait_n(5);
    repeat (7) pulse(10);
    wait_n(124);
    check("R7 not before window end", {31'b0, res_ready}, 32'h0);
    wait_n(1);
    check("R7 window ready", {31'b0, res_ready}, 32'h1);
    check("R7 window count", win_val(), 32'd7);
    check("R7 byte2 zero", {24'h0, data_b2}, 32'h0);
    repeat (3) pulse(10);
    wait_n(169);
    check("R10 previous window held", win_val(), 32'd7);
    wait_n(1);
    check("R10 second window count", win_val(), 32'd3);
  endtask

  task automatic t_window_zero();
    meas_en    = 1'b0;
    win_len_ms = 16'd0;
    wait_n(2);
    meas_en = 1'b1;
    wait_n(2);
    pulse(5);
    pulse(5);
    wait_n(7);
    check("R7 zero length not early", {31'b0, res_ready}, 32'h0);
    wait_n(1);
    check("R7 zero length as one ms", win_val(), 32'd2);
  endtask

  initial begin
    t_reset();
    t_period();
    t_disabled();
    t_timeout();
    t_mode_switch();
    t_window();
    t_window_zero();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule